// File: doc/BRIEF.md
# Dual-Edge Masked Interrupt Controller

This block collects up to sixteen level-type status lines from a peripheral, such as a microphone short-detect line, and raises one shared interrupt toward a host. Each line is brought into the local clock domain and watched for change. Both directions count: a press (high to low) and a release (low to high) are each an event. An event on a line whose mask bit is set latches a hidden pending bit. Any pending bit pulls the active-low, open-drain interrupt line low. The line is modelled as an output-enable, and an external pull-up is assumed.

The host uses a small register port. It has two mask registers and two status registers, each eight bits wide. A status register returns the present synchronised level of its eight lines, not a sticky flag. Reading it also retires the pending bits of that group, which releases the interrupt. The host therefore learns the new level and acknowledges the event in a single access.

Top module: `dual_edge_irq_ctrl`

## Requirements
- R1: After reset both mask registers read 0x00, `irq_oe_o` is 0 (line released) and `rdata_o` is 0x00.
- R2: Mask group 0 is read and written at address 0x5E and mask group 1 at 0x5F. A mask bit of 1 unmasks the source of the same index in its group. `src_i[7:0]` form group 0 and `src_i[15:8]` form group 1.
- R3: A read at 0x60 returns the synchronised level of `src_i[7:0]`, with bit 6 being the mic short-detect line. A read at 0x61 returns the level of `src_i[15:8]`. The level is returned regardless of mask or pending state. `rdata_o` is updated at the clock edge that samples `rd_i` and holds its value until the next read.
- R4: A high-to-low change on an unmasked source drives `irq_oe_o` to 1 at the third rising clock edge after the change, and not before.
- R5: A low-to-high change on an unmasked source also drives `irq_oe_o` to 1 with the same three-edge latency.
- R6: Edges on masked sources never assert `irq_oe_o`.
- R7: Once asserted, `irq_oe_o` stays at 1 until the status register that covers the pending source is read. A read at 0x60 retires only group 0 pending bits, and a read at 0x61 retires only group 1 pending bits.
- R8: An edge detected in the same cycle as the clearing status read leaves that pending bit set, so the interrupt stays asserted.
- R9: Writing 0 to a mask bit retires that source's pending bit at the same clock edge as the write.
- R10: Writes to the status addresses or to unmapped addresses change no mask. A read of an unmapped address returns 0x00.
- R11: Writing 0x40 to address 0x5E makes source 6 the only cause of interrupts in group 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Asynchronous level sources, two groups of eight |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_oe_o | output | 1 | 1 pulls the open-drain interrupt line low |

## Verification
The assertions assume that `rd_i` and `wr_i` are never high in the same cycle. They also assume that each change on a source is held long enough to pass the two synchroniser flops, so that one input change gives exactly one detected edge. The stimulus drives one register access at a time on the falling clock edge. After each batch of source toggles it waits several cycles before toggling again, so every change is seen once. The bench's own pending-bit model is updated only once each change has settled.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned GRP_W   = 8;
  localparam int unsigned NUM_GRP = 2;
  localparam int unsigned ADDR_W  = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK0,
    SEL_MASK1,
    SEL_STAT0,
    SEL_STAT1
  } reg_sel_e;
endpackage

// File: rtl/src_sync.sv
module src_sync #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] edge_o
);
  logic [N-1:0] meta_q, lvl_q, prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= 1'b0;
        lvl_q[i]  <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= src_i[i];
        lvl_q[i]  <= meta_q[i];
        prev_q[i] <= lvl_q[i];
      end
    end
    assign edge_o[i] = lvl_q[i] ^ prev_q[i];
  end

  assign level_o = lvl_q;

  // R4 / R5: a change at the input reaches the level two edges later
  a_r4_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meta_q != lvl_q) |=> (lvl_q == $past(meta_q)));
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_mask_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  input  logic [W-1:0] edge_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] mask_q, mask_d, pend_q, pend_d;

  always_comb begin
    mask_d = wr_mask_i ? wdata_i : mask_q;
    // new edge wins over a clear in the same cycle; mask gates immediately
    pend_d = mask_d & (edge_i | (pend_q & {W{~clr_i}}));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;

  a_r6_masked_never_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~mask_q) == '0);

  a_r7_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr_mask_i && edge_i == '0) |=> (pend_q == '0));

  a_r7_hold_until_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !wr_mask_i) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  a_r8_edge_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr_mask_i && (edge_i & mask_q) != '0) |=> (pend_q != '0));

  a_r9_mask_drops_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_i |=> ((pend_q & ~$past(wdata_i)) == '0));
endmodule

// File: rtl/reg_port.sv
module reg_port
  import irq_pkg::*;
#(
  parameter int unsigned         W        = GRP_W,
  parameter int unsigned         AW       = ADDR_W,
  parameter logic [AW-1:0]       MASK0_AD = 8'h5E,
  parameter logic [AW-1:0]       MASK1_AD = 8'h5F,
  parameter logic [AW-1:0]       STAT0_AD = 8'h60,
  parameter logic [AW-1:0]       STAT1_AD = 8'h61
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [1:0][W-1:0]    mask_i,
  input  logic [1:0][W-1:0]    level_i,
  output logic [1:0]           wr_mask_o,
  output logic [1:0]           clr_o,
  output logic [W-1:0]         rdata_o
);
  reg_sel_e     sel;
  logic [W-1:0] rdata_q, rmux;

  always_comb begin
    unique case (addr_i)
      MASK0_AD: sel = SEL_MASK0;
      MASK1_AD: sel = SEL_MASK1;
      STAT0_AD: sel = SEL_STAT0;
      STAT1_AD: sel = SEL_STAT1;
      default:  sel = SEL_NONE;
    endcase
  end

  always_comb begin
    case (sel)
      SEL_MASK0: rmux = mask_i[0];
      SEL_MASK1: rmux = mask_i[1];
      SEL_STAT0: rmux = level_i[0];
      SEL_STAT1: rmux = level_i[1];
      default:   rmux = '0;
    endcase
  end

  assign wr_mask_o[0] = wr_i && (sel == SEL_MASK0);
  assign wr_mask_o[1] = wr_i && (sel == SEL_MASK1);
  assign clr_o[0]     = rd_i && (sel == SEL_STAT0);
  assign clr_o[1]     = rd_i && (sel == SEL_STAT1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rmux;
  end

  assign rdata_o = rdata_q;

  a_r3_status_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == STAT0_AD) |=> (rdata_o == $past(level_i[0])));

  a_r3_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel == SEL_NONE) |=> (rdata_o == '0));

  a_r2_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({wr_mask_o, clr_o}) <= 1);
endmodule

// File: rtl/dual_edge_irq_ctrl.sv
module dual_edge_irq_ctrl
  import irq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_GRP*GRP_W-1:0] src_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic [GRP_W-1:0]      wdata_i,
  output logic [GRP_W-1:0]      rdata_o,
  output logic                  irq_oe_o
);
  localparam int unsigned NSRC = NUM_GRP * GRP_W;

  logic [NSRC-1:0]             level, edges;
  logic [1:0][GRP_W-1:0]       mask, pend, level_g;
  logic [1:0]                  wr_mask, clr;

  src_sync #(.N(NSRC)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_i),
    .level_o (level),
    .edge_o  (edges)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
    assign level_g[g] = level[g*GRP_W +: GRP_W];
    irq_bank #(.W(GRP_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_mask_i (wr_mask[g]),
      .wdata_i   (wdata_i),
      .clr_i     (clr[g]),
      .edge_i    (edges[g*GRP_W +: GRP_W]),
      .mask_o    (mask[g]),
      .pend_o    (pend[g])
    );
  end

  reg_port #(.W(GRP_W), .AW(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .mask_i    (mask),
    .level_i   (level_g),
    .wr_mask_o (wr_mask),
    .clr_o     (clr),
    .rdata_o   (rdata_o)
  );

  assign irq_oe_o = |pend;

  a_r6_no_spurious_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_oe_o && (edges & {mask[1], mask[0]}) == '0) |=> !irq_oe_o);

  a_r4_edge_raises_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edges & {mask[1], mask[0]}) != '0 && !wr_i) |=> irq_oe_o);

  a_r10_protocol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));
endmodule

// File: tb/dual_edge_irq_ctrl_bench.sv
module dual_edge_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic [7:0]  addr = '0, wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  rdata;
  logic        irq_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_mask [2];
  logic [7:0] exp_pend [2];

  always #2 clk = ~clk;  // 250 MHz

  dual_edge_irq_ctrl u_dual_edge_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .rd_i(rd),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_oe_o(irq_oe)
  );

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic bit exp_irq();
    return (exp_pend[0] | exp_pend[1]) != 0;
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    if (a == 8'h5E) begin exp_mask[0] = d; exp_pend[0] &= d; end
    if (a == 8'h5F) begin exp_mask[1] = d; exp_pend[1] &= d; end
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
    if (a == 8'h60) exp_pend[0] = '0;
    if (a == 8'h61) exp_pend[1] = '0;
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'h5E: return exp_mask[0];
      8'h5F: return exp_mask[1];
      8'h60: return src[7:0];
      8'h61: return src[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic toggle(input logic [15:0] t);
    @(negedge clk); src ^= t;
    repeat (4) @(negedge clk);
    exp_pend[0] |= t[7:0] & exp_mask[0];
    exp_pend[1] |= t[15:8] & exp_mask[1];
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    exp_mask[0] = '0; exp_mask[1] = '0; exp_pend[0] = '0; exp_pend[1] = '0;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(irq_oe == 1'b0, "R1 irq", irq_oe, 0);
    check(rdata == 8'h00, "R1 rdata", rdata, 0);
    do_read(8'h5E, d); check(d == 8'h00, "R1 mask0", d, 0);
    do_read(8'h5F, d); check(d == 8'h00, "R1 mask1", d, 0);
    // R2
    do_write(8'h5E, 8'hA5); do_read(8'h5E, d); check(d == 8'hA5, "R2 mask0 rw", d, 8'hA5);
    do_write(8'h5F, 8'h3C); do_read(8'h5F, d); check(d == 8'h3C, "R2 mask1 rw", d, 8'h3C);
    // R10: writes to status/unmapped ignored
    do_write(8'h60, 8'hFF); do_write(8'h61, 8'hFF); do_write(8'h33, 8'hFF);
    do_read(8'h5E, d); check(d == 8'hA5, "R10 mask0 kept", d, 8'hA5);
    do_read(8'h5F, d); check(d == 8'h3C, "R10 mask1 kept", d, 8'h3C);
    do_read(8'h7F, d); check(d == 8'h00, "R10 unmapped read", d, 0);
    // R11 / R6: only source 6 unmasked
    do_write(8'h5E, 8'h40); do_write(8'h5F, 8'h00);
    toggle(16'hFFBF);
    check(irq_oe == 1'b0, "R6 masked edges", irq_oe, 0);
    // R3: live levels
    do_read(8'h60, d); check(d == 8'hBF, "R3 stat0 level", d, 8'hBF);
    do_read(8'h61, d); check(d == 8'hFF, "R3 stat1 level", d, 8'hFF);
    // R5 rising edge on source 6, exact latency
    @(negedge clk); src[6] = 1'b1;
    @(negedge clk); check(irq_oe == 1'b0, "R5 early edge1", irq_oe, 0);
    @(negedge clk); check(irq_oe == 1'b0, "R5 early edge2", irq_oe, 0);
    @(negedge clk); check(irq_oe == 1'b1, "R5 rise asserts", irq_oe, 1);
    exp_pend[0] = 8'h40;
    // R7: group-1 read does not clear, group-0 read does
    do_read(8'h61, d); check(irq_oe == 1'b1, "R7 other group read", irq_oe, 1);
    do_read(8'h60, d); check(d[6] == 1'b1, "R3 bit6 level", d[6], 1);
    check(irq_oe == 1'b0, "R7 release on read", irq_oe, 0);
    // R4 falling edge
    @(negedge clk); src[6] = 1'b0;
    @(negedge clk); @(negedge clk);
    check(irq_oe == 1'b0, "R4 early", irq_oe, 0);
    @(negedge clk); check(irq_oe == 1'b1, "R4 fall asserts", irq_oe, 1);
    repeat (5) @(negedge clk); check(irq_oe == 1'b1, "R7 holds", irq_oe, 1);
    do_read(8'h60, d); check(d[6] == 1'b0, "R3 bit6 low", d[6], 0);
    check(irq_oe == 1'b0, "R7 cleared", irq_oe, 0);
    // R8: edge in the clearing-read cycle
    @(negedge clk); src[6] = 1'b1;
    @(negedge clk); @(negedge clk);
    addr = 8'h60; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    check(irq_oe == 1'b1, "R8 edge beats clear", irq_oe, 1);
    do_read(8'h60, d); check(irq_oe == 1'b0, "R8 later clear", irq_oe, 0);
    exp_pend[0] = '0;
    // R9: masking clears pending
    toggle(16'h0040); check(irq_oe == 1'b1, "R9 setup", irq_oe, 1);
    do_write(8'h5E, 8'h00); check(irq_oe == 1'b0, "R9 mask clears", irq_oe, 0);
    do_write(8'h5E, 8'h40); check(irq_oe == 1'b0, "R9 unmask no revive", irq_oe, 0);
    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) begin
        logic [7:0] a;
        a = ($urandom_range(0, 1) != 0) ? 8'h5E : 8'h5F;
        do_write(a, 8'($urandom));
      end else if (op == 1) begin
        toggle(16'($urandom) & 16'($urandom));
      end else begin
        logic [7:0] a, e;
        a = 8'h5E + 8'($urandom_range(0, 4));
        e = exp_read(a);
        do_read(a, d);
        check(d == e, "R3 random read", d, e);
      end
      check(irq_oe == exp_irq(), "R7 random irq", irq_oe, exp_irq());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule